// File: doc/BRIEF.md
# Frame-Synchronous Shadow Register Bank

This block holds the control registers of a multi-window display pipeline. Each register has two copies. Software writes the pending copy. The active copy feeds the rest of the pipeline. On a vertical sync pulse, each window copies its whole pending set into its active set in one step. A window that is protected skips that copy, so software can change several of its registers over many cycles and have them take effect together at a single frame boundary.

Each window has four registers: control (bit 0 is the window enable), buffer start address, buffer size and color key. A shared block holds one channel-path enable bit per window, which is also double buffered, and the protect register, which takes effect at once. A parameter chooses between two protect styles: one protect bit per window, or a single global bit that guards every window. Software can read either copy of any register. When the pending and active start addresses are equal, software knows that a buffer flip has landed. By default the lowest window has no color-key register.

Top module: `frame_shadow_bank`

## Requirements
- R1: After reset, every pending and active register, every channel-path bit and the protect register read as zero, and `act_en` and `act_chan` are zero.
- R2: A write to a window register (address = {window index, field}, with field 0 control, 1 start address, 2 size, 3 key) updates the pending copy on the next clock edge. The active copy and `act_en` do not change until a clock edge with `vsync` high.
- R3: On a clock edge with `vsync` high, every unprotected window copies all of its pending fields, and its channel-path bit, into its active copy.
- R4: In per-window protect mode, protect bit w (shared index NWIN, field 1, bits [NWIN-1:0]) stops window w's vsync copy while the bit is set and leaves the other windows unaffected. The held values move to the active copy at the first vsync after the bit is cleared.
- R5: In global protect mode, only bit 0 of the protect register is stored, and while it is set no window copies at vsync. It reads back as 0 or 1.
- R6: Clearing the enable bit (control bit 0) of a window leaves `act_en` high until the next unprotected vsync.
- R7: The channel-path register (shared index NWIN, field 0, bit w for window w) is double buffered. `act_chan[w]` follows the active copy.
- R8: `rd_active`=1 returns the active copy and 0 returns the pending copy. After a transfer, both copies of the start address read the same value.
- R9: Windows below KEY_FROM have no key register: writes to field 3 are ignored and both copies read as zero. Windows at KEY_FROM and above store a key.
- R10: When a write and a vsync transfer happen on the same edge, the active copy takes the old pending value, and the new value stays pending until the next vsync.
- R11: The protect register reads the same in both copies and takes effect at once. Addresses with an index above NWIN, and shared fields 2 and 3, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync | input | 1 | One-cycle frame boundary pulse |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W (5) | Write address {index, field} |
| wr_data | input | DATA_W (32) | Write data |
| rd_addr | input | ADDR_W (5) | Read address {index, field} |
| rd_active | input | 1 | 1 selects the active copy, 0 the pending copy |
| rd_data | output | DATA_W (32) | Combinational read data |
| act_en | output | NWIN (5) | Active window enable bits |
| act_chan | output | NWIN (5) | Active channel-path enable bits |

## Verification
Two instances, one in per-window protect mode and one in global protect mode, receive the same stimulus, so a single write of protect value 2 shows the two modes protecting different windows. The directed patterns are:
- writes without vsync, which separate the pending copy from the active copy;
- vsync with one window protected and another not, which separates per-window masking from a global stall;
- a write on the same edge as vsync, which separates old-value capture from write-through;
- a key write to window 0, which separates an absent register from a stored one.

A long stretch of random writes, vsync pulses and readbacks is then compared against a behavioural model on every clock.

// File: rtl/fsb_pkg.sv
`timescale 1ns/1ps
package fsb_pkg;
   localparam int NREG = 4;
   localparam logic [1:0] FLD_CTRL  = 2'd0;
   localparam logic [1:0] FLD_START = 2'd1;
   localparam logic [1:0] FLD_SIZE  = 2'd2;
   localparam logic [1:0] FLD_KEY   = 2'd3;
   localparam logic [1:0] SH_CHAN   = 2'd0;
   localparam logic [1:0] SH_PROT   = 2'd1;
endpackage

// File: rtl/fsb_guard.sv
`timescale 1ns/1ps
module fsb_guard #(
   parameter int NWIN    = 5,
   parameter int DATA_W  = 32,
   parameter bit PER_WIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prot_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              vsync,
   output logic [NWIN-1:0]   load,
   output logic [DATA_W-1:0] prot_rd
);
   if (DATA_W <= NWIN) begin : g_bad_width
      $error("fsb_guard: DATA_W must exceed NWIN");
   end

   if (PER_WIN) begin : g_per_win
      logic [NWIN-1:0] p_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       p_q <= '0;
         else if (prot_we) p_q <= wdata[NWIN-1:0];
      end
      assign load    = {NWIN{vsync}} & ~p_q;
      assign prot_rd = {{(DATA_W-NWIN){1'b0}}, p_q};
   end else begin : g_global
      logic g_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       g_q <= 1'b0;
         else if (prot_we) g_q <= wdata[0];
      end
      assign load    = {NWIN{vsync & ~g_q}};
      assign prot_rd = {{(DATA_W-1){1'b0}}, g_q};

      // R5: global mode loads all windows or none
      a_r5_all_or_none: assert property (@(posedge clk) disable iff (!rst_n)
         vsync |-> ($countones(load) == 0 || $countones(load) == NWIN));
   end
endmodule

// File: rtl/fsb_window.sv
`timescale 1ns/1ps
module fsb_window
   import fsb_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit HAS_KEY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_reg,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ch_we,
   input  logic              ch_bit,
   input  logic              load,
   input  logic [1:0]        rd_reg,
   input  logic              rd_active,
   output logic [DATA_W-1:0] rd_data,
   output logic              act_en,
   output logic              act_chan,
   output logic              pend_chan
);
   localparam int NUSED = HAS_KEY ? NREG : NREG - 1;
   localparam logic [1:0] LAST = 2'(NUSED - 1);

   logic [NREG-1:0][DATA_W-1:0] wr_q, act_q;
   logic ch_wr, ch_act;
   logic wr_ok;

   assign wr_ok = wr_en && (wr_reg <= LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q   <= '0;
         act_q  <= '0;
         ch_wr  <= 1'b0;
         ch_act <= 1'b0;
      end else begin
         if (load) begin
            act_q  <= wr_q;
            ch_act <= ch_wr;
         end
         if (wr_ok) wr_q[wr_reg] <= wdata;
         if (ch_we) ch_wr <= ch_bit;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_reg <= LAST) rd_data = rd_active ? act_q[rd_reg] : wr_q[rd_reg];
   end

   assign act_en    = act_q[FLD_CTRL][0];
   assign act_chan  = ch_act;
   assign pend_chan = ch_wr;

   // R10: a transfer captures the pending value from before the edge
   a_r10_old_value: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (act_q == $past(wr_q)));
   // R2: without a transfer the active copy holds
   a_r2_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(act_q) && $stable(ch_act));
endmodule

// File: rtl/frame_shadow_bank.sv
`timescale 1ns/1ps
module frame_shadow_bank
   import fsb_pkg::*;
#(
   parameter int NWIN         = 5,
   parameter int DATA_W       = 32,
   parameter int KEY_FROM     = 1,
   parameter bit PER_WIN_PROT = 1'b1,
   localparam int IDX_W  = $clog2(NWIN + 1),
   localparam int ADDR_W = IDX_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vsync,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_active,
   output logic [DATA_W-1:0] rd_data,
   output logic [NWIN-1:0]   act_en,
   output logic [NWIN-1:0]   act_chan
);
   if (NWIN < 1 || DATA_W <= NWIN || KEY_FROM < 0 || KEY_FROM > NWIN) begin : g_bad_cfg
      $error("frame_shadow_bank: illegal parameter set");
   end

   localparam logic [IDX_W-1:0] SH_IDX = IDX_W'(NWIN);

   logic [IDX_W-1:0]  wr_idx, rd_idx;
   logic [1:0]        wr_fld, rd_fld;
   logic              ch_we, prot_we;
   logic [NWIN-1:0]   load, chan_pend;
   logic [DATA_W-1:0] prot_rd;
   logic [DATA_W-1:0] win_rd [NWIN];

   assign wr_idx  = wr_addr[ADDR_W-1:2];
   assign wr_fld  = wr_addr[1:0];
   assign rd_idx  = rd_addr[ADDR_W-1:2];
   assign rd_fld  = rd_addr[1:0];
   assign ch_we   = wr_en && (wr_idx == SH_IDX) && (wr_fld == SH_CHAN);
   assign prot_we = wr_en && (wr_idx == SH_IDX) && (wr_fld == SH_PROT);

   fsb_guard #(.NWIN(NWIN), .DATA_W(DATA_W), .PER_WIN(PER_WIN_PROT)) u_guard (
      .clk(clk), .rst_n(rst_n), .prot_we(prot_we), .wdata(wr_data),
      .vsync(vsync), .load(load), .prot_rd(prot_rd));

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      fsb_window #(.DATA_W(DATA_W), .HAS_KEY(w >= KEY_FROM)) u_win (
         .clk(clk), .rst_n(rst_n),
         .wr_en(wr_en && (wr_idx == IDX_W'(w))), .wr_reg(wr_fld), .wdata(wr_data),
         .ch_we(ch_we), .ch_bit(wr_data[w]), .load(load[w]),
         .rd_reg(rd_fld), .rd_active(rd_active), .rd_data(win_rd[w]),
         .act_en(act_en[w]), .act_chan(act_chan[w]), .pend_chan(chan_pend[w]));

      // R4: a window held back at vsync keeps its active outputs
      a_r4_protect_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (vsync && !load[w]) |=> $stable(act_en[w]) && $stable(act_chan[w]));
      // R6: an enable only drops on a vsync edge
      a_r6_clear_at_vsync: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(act_en[w]) |-> $past(vsync));
   end

   always_comb begin
      rd_data = '0;
      for (int w = 0; w < NWIN; w++)
         if (rd_idx == IDX_W'(w)) rd_data = win_rd[w];
      if (rd_idx == SH_IDX) begin
         if (rd_fld == SH_CHAN)
            rd_data = {{(DATA_W-NWIN){1'b0}}, (rd_active ? act_chan : chan_pend)};
         else if (rd_fld == SH_PROT)
            rd_data = prot_rd;
      end
   end
endmodule

// File: tb/sim_frame_shadow_bank.sv
`timescale 1ns/1ps
module sim_frame_shadow_bank;
   localparam int NW = 5;
   localparam int DW = 32;
   localparam int AW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vsync = 1'b0, wr_en = 1'b0, rd_active = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd0, rd1;
   logic [NW-1:0] en0, ch0, en1, ch1;
   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   frame_shadow_bank #(.NWIN(NW), .DATA_W(DW), .KEY_FROM(1), .PER_WIN_PROT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .vsync(vsync), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_active(rd_active), .rd_data(rd0),
      .act_en(en0), .act_chan(ch0));
   frame_shadow_bank #(.NWIN(NW), .DATA_W(DW), .KEY_FROM(1), .PER_WIN_PROT(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .vsync(vsync), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_active(rd_active), .rd_data(rd1),
      .act_en(en1), .act_chan(ch1));

   // behavioural model, index [variant][window][field]; variant 0 per-window, 1 global
   logic [DW-1:0] m_wr  [2][NW][4];
   logic [DW-1:0] m_act [2][NW][4];
   logic [NW-1:0] m_chw [2];
   logic [NW-1:0] m_cha [2];
   logic [NW-1:0] m_prot[2];

   task automatic model_clear();
      for (int v = 0; v < 2; v++) begin
         for (int w = 0; w < NW; w++)
            for (int f = 0; f < 4; f++) begin m_wr[v][w][f] = '0; m_act[v][w][f] = '0; end
         m_chw[v] = '0; m_cha[v] = '0; m_prot[v] = '0;
      end
   endtask

   always @(posedge clk) begin
      if (rst_n) begin
         for (int v = 0; v < 2; v++) begin
            for (int w = 0; w < NW; w++) begin
               logic held;
               held = (v == 0) ? m_prot[v][w] : m_prot[v][0];
               if (vsync && !held) begin
                  for (int f = 0; f < 4; f++) m_act[v][w][f] = m_wr[v][w][f];
                  m_cha[v][w] = m_chw[v][w];
               end
            end
            if (wr_en) begin
               if (int'(wr_addr[4:2]) < NW) begin
                  if (!(wr_addr[4:2] == 0 && wr_addr[1:0] == 3))
                     m_wr[v][wr_addr[4:2]][wr_addr[1:0]] = wr_data;
               end else if (int'(wr_addr[4:2]) == NW) begin
                  if (wr_addr[1:0] == 0) m_chw[v] = wr_data[NW-1:0];
                  if (wr_addr[1:0] == 1)
                     m_prot[v] = (v == 0) ? wr_data[NW-1:0] : {{(NW-1){1'b0}}, wr_data[0]};
               end
            end
         end
      end
   end

   function automatic logic [DW-1:0] exp_read(int v, logic [AW-1:0] a, logic act);
      int idx = int'(a[4:2]);
      int f   = int'(a[1:0]);
      logic [NW-1:0] en;
      if (idx < NW) return (idx == 0 && f == 3) ? '0 : (act ? m_act[v][idx][f] : m_wr[v][idx][f]);
      if (idx == NW && f == 0) return {{(DW-NW){1'b0}}, (act ? m_cha[v] : m_chw[v])};
      if (idx == NW && f == 1) return {{(DW-NW){1'b0}}, m_prot[v]};
      en = '0;
      return {{(DW-NW){1'b0}}, en};
   endfunction

   task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   function automatic logic [NW-1:0] m_en(int v);
      logic [NW-1:0] e;
      for (int w = 0; w < NW; w++) e[w] = m_act[v][w][0][0];
      return e;
   endfunction

   // per-clock comparison of the active outputs (R3, R4, R5, R6, R7)
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R3 act_en u0",   {27'd0, en0}, {27'd0, m_en(0)});
         chk("R7 act_chan u0", {27'd0, ch0}, {27'd0, m_cha[0]});
         chk("R5 act_en u1",   {27'd0, en1}, {27'd0, m_en(1)});
         chk("R7 act_chan u1", {27'd0, ch1}, {27'd0, m_cha[1]});
      end
   end

   function automatic logic [AW-1:0] ad(int idx, int f);
      return AW'(idx * 4 + f);
   endfunction

   task automatic step(logic we, logic [AW-1:0] a, logic [DW-1:0] d, logic vs);
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d; vsync = vs;
      @(negedge clk);
      wr_en = 1'b0; wr_addr = '0; wr_data = '0; vsync = 1'b0;
   endtask

   task automatic rd_chk(string req, logic [AW-1:0] a, logic act);
      rd_addr = a; rd_active = act;
      #1;
      chk(req, rd0, exp_read(0, a, act));
      chk(req, rd1, exp_read(1, a, act));
   endtask

   task automatic rd_is(string req, int v, logic [AW-1:0] a, logic act, logic [DW-1:0] exp);
      rd_addr = a; rd_active = act;
      #1;
      chk(req, (v == 0) ? rd0 : rd1, exp);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 act_en", {27'd0, en0, en1[0]}, '0);
      for (int i = 0; i < 32; i++) begin
         rd_is("R1 pending", 0, AW'(i), 1'b0, '0);
         rd_is("R1 active", 1, AW'(i), 1'b1, '0);
      end
      rst_n = 1'b1;

      // R2: writes land in pending copy only
      step(1, ad(1, 0), 32'h1, 0);
      step(1, ad(1, 1), 32'hA000_0000, 0);
      step(1, ad(1, 2), 32'h0000_0400, 0);
      step(1, ad(1, 3), 32'h00FF_00FF, 0);
      rd_is("R2 pending start", 0, ad(1, 1), 1'b0, 32'hA000_0000);
      rd_is("R2 active start", 0, ad(1, 1), 1'b1, 32'h0);
      chk("R2 act_en before vsync", {27'd0, en0}, 32'h0);

      // R3, R8: vsync transfer and readback equality
      step(0, '0, '0, 1);
      rd_is("R8 active start", 0, ad(1, 1), 1'b1, 32'hA000_0000);
      rd_is("R3 active key", 0, ad(1, 3), 1'b1, 32'h00FF_00FF);
      chk("R3 act_en after vsync", {27'd0, en0}, 32'h2);

      // R4, R5: protect window 1 (u1 only stores bit 0, so it stays unprotected)
      step(1, ad(NW, 1), 32'h2, 0);
      rd_is("R11 protect readback", 0, ad(NW, 1), 1'b1, 32'h2);
      rd_is("R5 global readback", 1, ad(NW, 1), 1'b0, 32'h0);
      step(1, ad(1, 1), 32'hB000_0000, 0);
      step(1, ad(2, 0), 32'h1, 0);
      step(0, '0, '0, 1);
      rd_is("R4 protected stays", 0, ad(1, 1), 1'b1, 32'hA000_0000);
      rd_is("R4 other window moves", 0, ad(2, 0), 1'b1, 32'h1);
      rd_is("R5 bit1 ignored", 1, ad(1, 1), 1'b1, 32'hB000_0000);
      step(1, ad(NW, 1), 32'h0, 0);
      rd_is("R4 still pending", 0, ad(1, 1), 1'b1, 32'hA000_0000);
      step(0, '0, '0, 1);
      rd_is("R4 lands after clear", 0, ad(1, 1), 1'b1, 32'hB000_0000);

      // R5: global bit stalls every window in u1, only window 0 in u0
      step(1, ad(NW, 1), 32'h1, 0);
      step(1, ad(0, 0), 32'h1, 0);
      step(1, ad(3, 0), 32'h1, 0);
      step(0, '0, '0, 1);
      chk("R5 global stall", {27'd0, en1}, 32'h6);
      chk("R4 window0 only", {27'd0, en0}, 32'hE);
      step(1, ad(NW, 1), 32'h0, 0);
      step(0, '0, '0, 1);
      chk("R5 released", {27'd0, en1}, 32'hF);

      // R6: enable clear deferred to vsync
      step(1, ad(3, 0), 32'h0, 0);
      chk("R6 still enabled", {27'd0, en0[3]}, 32'h1);
      step(0, '0, '0, 1);
      chk("R6 cleared at vsync", {27'd0, en0[3]}, 32'h0);

      // R7: channel path register
      step(1, ad(NW, 0), 32'h0A, 0);
      rd_is("R7 pending chan", 0, ad(NW, 0), 1'b0, 32'h0A);
      chk("R7 act_chan before", {27'd0, ch0}, 32'h0);
      step(0, '0, '0, 1);
      chk("R7 act_chan after", {27'd0, ch0}, 32'h0A);

      // R10: write on the vsync edge
      step(1, ad(2, 1), 32'hC000_0000, 1);
      rd_is("R10 active old", 0, ad(2, 1), 1'b1, 32'h0);
      rd_is("R10 pending new", 0, ad(2, 1), 1'b0, 32'hC000_0000);
      step(0, '0, '0, 1);
      rd_is("R10 lands next", 0, ad(2, 1), 1'b1, 32'hC000_0000);

      // R9: window 0 has no key
      step(1, ad(0, 3), 32'hDEAD_BEEF, 1);
      rd_is("R9 no key pending", 0, ad(0, 3), 1'b0, 32'h0);
      rd_is("R9 no key active", 0, ad(0, 3), 1'b1, 32'h0);
      step(1, ad(4, 3), 32'h1234_5678, 0);
      step(0, '0, '0, 1);
      rd_is("R9 key stored", 0, ad(4, 3), 1'b1, 32'h1234_5678);

      // R11: unmapped reads
      rd_is("R11 idx6", 0, ad(6, 0), 1'b1, 32'h0);
      rd_is("R11 idx7", 0, ad(7, 2), 1'b0, 32'h0);
      rd_is("R11 shared f2", 0, ad(NW, 2), 1'b1, 32'h0);

      // random mix checked against the model
      for (int n = 0; n < 600; n++) begin
         logic [AW-1:0] a;
         a = AW'($urandom_range(0, 23));
         step(($urandom_range(0, 3) != 0), a, $urandom, ($urandom_range(0, 4) == 0));
         rd_chk("R8 random read", AW'($urandom_range(0, 31)), $urandom_range(0, 1) == 1);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule